// File: doc/BRIEF.md
# Dual-Lane Serial DAC Frame Transmitter

This block sits on the host side of a pair of dual-channel 8-bit DAC chips. The chips share one serial clock and one active-low frame-sync line, and each has its own data line. The caller hands over two 16-bit command words, one per chip, through a valid/ready handshake. The block then shifts both words out at the same time, most significant bit first, inside a single sync-low frame. When sync returns high, both chips act on their commands together.

The serial clock comes from the system clock. Its high and low phases each last `HALF_DIV` system cycles. Data changes on the falling edge of the serial clock, so the chips can sample it on the rising edge. The clock stays low while no frame is in progress.

The transmitter always clears the reference-select bit (bit 15), so both chips stay on their internal reference. A small combinational helper, `dac_cmd_pack`, builds a command word from named fields.

Top module: `dual_dac_frame_tx`

## Requirements
- R1: While reset is held and right after it, sync_n is 1, sclk is 0, in_ready is 1, and sdo_a and sdo_b are 0.
- R2: in_ready is 1 only while no frame or inter-frame gap is in progress. A word pair is taken exactly once, on a clock edge where in_valid and in_ready are both 1, and sync_n falls on that edge.
- R3: Each frame holds sync_n low for exactly 32·HALF_DIV system cycles and contains exactly 16 rising sclk edges.
- R4: On rising sclk edge k (k = 1..16) of a frame, sdo_a carries bit 16−k of word_a and sdo_b carries bit 16−k of word_b. The order is MSB first, and each lane carries only its own word.
- R5: Bit 15 of each transmitted word is 0, whatever the caller supplied.
- R6: sclk is 0 whenever sync_n is 1. sdo_a and sdo_b change only when sclk falls or when sync_n falls.
- R7: Each sclk high phase lasts HALF_DIV system cycles. The first rising edge comes HALF_DIV cycles after sync_n falls.
- R8: Between two frames, sync_n stays high for at least 2·HALF_DIV system cycles (one serial clock period), even when in_valid is held at 1 throughout.
- R9: `dac_cmd_pack` produces a 16-bit word laid out as follows:
  - bit 15 = 0 (reference select);
  - bit 14 = 0;
  - bit 13 = upd_now;
  - bit 12 = pwr_dn_b;
  - bit 11 = pwr_dn_a;
  - bit 10 = sel_b;
  - bits 9:8 = ctl;
  - bits 7:0 = level.
- R10: word_a and word_b have no effect while in_valid is 0 or while a frame is running. No frame starts, and a running frame keeps the words that were captured when it started.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low reset |
| in_valid | input | 1 | Word pair offered |
| in_ready | output | 1 | Block idle and able to take a pair |
| word_a | input | CMD_W | Command word for lane A |
| word_b | input | CMD_W | Command word for lane B |
| sclk | output | 1 | Shared serial clock |
| sync_n | output | 1 | Shared active-low frame sync |
| sdo_a | output | 1 | Serial data to chip A |
| sdo_b | output | 1 | Serial data to chip B |

## Verification
The two lanes are driven with patterns that expose specific faults:
- Complementary all-ones and all-zeros words catch swapped lanes and a reference bit that is not cleared.
- Alternating 0xAAAA and 0x5555 words catch an off-by-one shift.
- Asymmetric words such as 0x1234 and 0x8001 catch reversed bit order.

Frames sent back to back with valid held high check the inter-frame gap and the single take per handshake. Words changed during a frame, or while valid is low, must never appear on the lines. The divider is run at a non-default ratio so that phase lengths tied to the parameter can be told apart from fixed ones.

// File: rtl/dac_cmd_pack.sv
module dac_cmd_pack (
  input  logic       upd_now,
  input  logic       pwr_dn_b,
  input  logic       pwr_dn_a,
  input  logic       sel_b,
  input  logic [1:0] ctl,
  input  logic [7:0] level,
  output logic [15:0] cmd
);
  assign cmd = {1'b0, 1'b0, upd_now, pwr_dn_b, pwr_dn_a, sel_b, ctl, level};
endmodule

// File: rtl/dual_dac_frame_tx.sv
module dual_dac_frame_tx #(
  parameter int HALF_DIV = 2,
  parameter int CMD_W    = 16
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             in_valid,
  output logic             in_ready,
  input  logic [CMD_W-1:0] word_a,
  input  logic [CMD_W-1:0] word_b,
  output logic             sclk,
  output logic             sync_n,
  output logic             sdo_a,
  output logic             sdo_b
);
  localparam int CW = $clog2(2*HALF_DIV) + 1;
  localparam int BW = $clog2(CMD_W);
  localparam logic [CW-1:0] HALF_LD  = CW'(HALF_DIV - 1);
  localparam logic [CW-1:0] GAP_LD   = CW'(2*HALF_DIV - 1);
  localparam logic [BW-1:0] LAST_BIT = BW'(CMD_W - 1);

  typedef enum logic [1:0] {S_IDLE, S_SHIFT, S_GAP} st_t;

  st_t             st;
  logic [CW-1:0]   tick;
  logic [BW-1:0]   bits;
  logic [CMD_W-1:0] sh_a, sh_b;

  wire take     = in_valid && in_ready;
  wire tick_end = (tick == '0);

  assign in_ready = (st == S_IDLE);
  assign sdo_a    = sh_a[CMD_W-1];
  assign sdo_b    = sh_b[CMD_W-1];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st     <= S_IDLE;
      tick   <= '0;
      bits   <= '0;
      sclk   <= 1'b0;
      sync_n <= 1'b1;
      sh_a   <= '0;
      sh_b   <= '0;
    end else begin
      case (st)
        S_IDLE: if (take) begin
          st     <= S_SHIFT;
          sync_n <= 1'b0;
          tick   <= HALF_LD;
          bits   <= '0;
          sh_a   <= {1'b0, word_a[CMD_W-2:0]};
          sh_b   <= {1'b0, word_b[CMD_W-2:0]};
        end
        S_SHIFT: begin
          if (!tick_end) tick <= tick - 1'b1;
          else begin
            tick <= HALF_LD;
            if (!sclk) sclk <= 1'b1;
            else begin
              sclk <= 1'b0;
              if (bits == LAST_BIT) begin
                st     <= S_GAP;
                sync_n <= 1'b1;
                tick   <= GAP_LD;
              end else begin
                bits <= bits + 1'b1;
                sh_a <= sh_a << 1;
                sh_b <= sh_b << 1;
              end
            end
          end
        end
        S_GAP: begin
          if (tick_end) st <= S_IDLE;
          else tick <= tick - 1'b1;
        end
        default: st <= S_IDLE;
      endcase
    end
  end
endmodule

// File: rtl/dual_dac_frame_tx_chk.sv
module dual_dac_frame_tx_chk #(
  parameter int CMD_W = 16
) (
  input logic clk,
  input logic rst_n,
  input logic in_valid,
  input logic in_ready,
  input logic sclk,
  input logic sync_n,
  input logic sdo_a,
  input logic sdo_b
);
  logic       sclk_q;
  logic [6:0] rise_cnt;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sclk_q   <= 1'b0;
      rise_cnt <= '0;
    end else begin
      sclk_q <= sclk;
      if (sync_n) rise_cnt <= '0;
      else if (sclk && !sclk_q) rise_cnt <= rise_cnt + 1'b1;
    end
  end

  AST_READY_ONLY_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
    in_ready |-> sync_n); // R2
  AST_TAKE_STARTS_FRAME: assert property (@(posedge clk) disable iff (!rst_n)
    (in_valid && in_ready) |=> $fell(sync_n)); // R2
  AST_FRAME_RISES: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(sync_n) |-> (rise_cnt == 7'(CMD_W))); // R3
  AST_REF_BIT_LOW: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(sync_n) |-> (!sdo_a && !sdo_b)); // R5
  AST_CLK_PARKED: assert property (@(posedge clk) disable iff (!rst_n)
    sync_n |-> !sclk); // R6
  AST_DATA_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    (!$fell(sclk) && !$fell(sync_n)) |-> ($stable(sdo_a) && $stable(sdo_b))); // R6
endmodule

bind dual_dac_frame_tx dual_dac_frame_tx_chk #(.CMD_W(CMD_W)) u_chk (.*);

// File: tb/sim_dual_dac_frame_tx.sv
`timescale 1ns/1ps
module sim_dual_dac_frame_tx;
  localparam int N = 3;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic in_valid = 1'b0;
  logic [15:0] word_a = '0, word_b = '0;
  logic in_ready, sclk, sync_n, sdo_a, sdo_b;

  logic upd_now, pwr_dn_b, pwr_dn_a, sel_b;
  logic [1:0] ctl;
  logic [7:0] level;
  logic [15:0] packed_cmd;

  int checks = 0, fails = 0, sent = 0, frames = 0, falls = 0;
  bit done = 1'b0;
  logic [31:0] exp_q[$];

  always #2.5 clk = ~clk;

  dual_dac_frame_tx #(.HALF_DIV(N), .CMD_W(16)) u0 (
    .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_ready(in_ready),
    .word_a(word_a), .word_b(word_b), .sclk(sclk), .sync_n(sync_n),
    .sdo_a(sdo_a), .sdo_b(sdo_b));

  dac_cmd_pack u_pack (
    .upd_now(upd_now), .pwr_dn_b(pwr_dn_b), .pwr_dn_a(pwr_dn_a),
    .sel_b(sel_b), .ctl(ctl), .level(level), .cmd(packed_cmd));

  task automatic chk(input bit ok, input string req, input string what,
                     input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s %s: actual %h expected %h", req, what, act, exp);
    end
  endtask

  task automatic send(input logic [15:0] a, input logic [15:0] b, input bit hold);
    word_a = a; word_b = b; in_valid = 1'b1;
    forever begin
      if (in_ready) begin
        exp_q.push_back({1'b0, a[14:0], 1'b0, b[14:0]});
        sent++;
        @(negedge clk);
        break;
      end
      @(negedge clk);
    end
    if (!hold) in_valid = 1'b0;
  endtask

  logic prev_sclk = 1'b0, prev_sync = 1'b1, prev_a = 1'b0, prev_b = 1'b0;
  int low_len, rises, pre_rise, high_run, gap_len;
  bit div_ok, hold_ok;
  logic [15:0] cap_a, cap_b;

  always @(negedge clk) begin
    if (rst_n) begin
      if (prev_sync && !sync_n) begin
        falls++;
        if (frames > 0) chk(gap_len >= 2*N, "R8", "sync high gap", gap_len, 2*N);
        low_len = 0; rises = 0; pre_rise = 0; high_run = 0;
        div_ok = 1'b1; hold_ok = 1'b1;
      end
      if (!sync_n) begin
        low_len++;
        if (sclk) begin
          if (!prev_sclk) begin
            rises++;
            cap_a = {cap_a[14:0], sdo_a};
            cap_b = {cap_b[14:0], sdo_b};
          end else if (sdo_a != prev_a || sdo_b != prev_b) hold_ok = 1'b0;
          high_run++;
        end else begin
          if (prev_sclk) begin
            if (high_run != N) div_ok = 1'b0;
            high_run = 0;
          end
          if (rises == 0) pre_rise++;
        end
      end
      if (!prev_sync && sync_n) begin
        logic [31:0] e;
        frames++;
        if (high_run != N) div_ok = 1'b0;
        if (exp_q.size() == 0) chk(1'b0, "R2", "frame without accepted pair", frames, 0);
        else begin
          e = exp_q.pop_front();
          chk(cap_a == e[31:16], "R4/R5", "lane A word", cap_a, e[31:16]);
          chk(cap_b == e[15:0],  "R4/R5", "lane B word", cap_b, e[15:0]);
        end
        chk(rises == 16, "R3", "rising edges", rises, 16);
        chk(low_len == 32*N, "R3", "sync low cycles", low_len, 32*N);
        chk(div_ok && pre_rise == N, "R7", "divider phases", pre_rise, N);
        chk(hold_ok, "R6", "data stable while sclk high", hold_ok, 1);
        gap_len = 0;
      end
      if (sync_n) begin
        gap_len++;
        if (sclk) chk(1'b0, "R6", "sclk high while sync high", sclk, 0);
      end
      prev_sclk = sclk; prev_sync = sync_n; prev_a = sdo_a; prev_b = sdo_b;
    end
  end

  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      done = 1'b1;
      chk(1'b0, "ALL", "watchdog expired", 0, 1);
      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    chk(sync_n == 1'b1 && sclk == 1'b0 && in_ready == 1'b1, "R1", "reset outputs",
        {sync_n, sclk, in_ready}, 3'b101);
    chk(sdo_a == 1'b0 && sdo_b == 1'b0, "R1", "reset data lines", {sdo_a, sdo_b}, 0);
    rst_n = 1'b1;
    @(negedge clk);
    chk(sync_n && !sclk && in_ready, "R1", "outputs after reset", {sync_n, sclk, in_ready}, 3'b101);

    for (int i = 0; i < 40; i++) begin
      word_a = 16'(i * 16'h1111); word_b = ~word_a;
      @(negedge clk);
    end
    chk(falls == 0, "R10", "no frame while valid low", falls, 0);

    send(16'hFFFF, 16'h0000, 0);
    send(16'hAAAA, 16'h5555, 0);
    word_a = 16'hDEAD; word_b = 16'hBEEF;
    repeat (20) @(negedge clk);
    chk(in_ready == 1'b0, "R2", "not ready during frame", in_ready, 0);
    send(16'h1234, 16'h8001, 0);

    upd_now = 1'b1; pwr_dn_b = 1'b0; pwr_dn_a = 1'b1; sel_b = 1'b0;
    ctl = 2'b10; level = 8'hC3;
    #1;
    chk(packed_cmd == 16'h2AC3, "R9", "helper word 1", packed_cmd, 16'h2AC3);
    upd_now = 1'b0; pwr_dn_b = 1'b1; pwr_dn_a = 1'b0; sel_b = 1'b1;
    ctl = 2'b01; level = 8'h5A;
    #1;
    chk(packed_cmd == 16'h155A, "R9", "helper word 2", packed_cmd, 16'h155A);
    @(negedge clk);
    send(16'h2AC3, packed_cmd, 0);

    send(16'h0F0F, 16'hF0F0, 1);
    send(16'h8000, 16'h0001, 1);
    send(16'h7FFE, 16'h4002, 0);

    while (frames < sent) @(negedge clk);
    repeat (4*N) @(negedge clk);
    chk(frames == sent && exp_q.size() == 0, "R2", "one frame per accepted pair", frames, sent);
    chk(falls == sent, "R10", "no extra frame from held words", falls, sent);

    if (!done) begin
      done = 1'b1;
      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
    end
  end
endmodule